// File: doc/BRIEF.md
# Line-Adaptive Blanking Period Selector

This block sets the blanking window for each cycle of a valley-switching flyback controller. It takes a digitised feedback voltage, whose level follows the load, and turns it into a blanking period expressed in clock cycles. A downstream timer consumes that period. At heavy load the window is short (high frequency). At light load it is long (low frequency). Between those two regions the period moves linearly with the feedback code.

Two curves exist, one for a low mains voltage and one for a high one. The curve in use follows a line-state flag. The flag is derived from a pair of line-current comparators that are sampled while the power switch conducts. The flag moves to high line as soon as one sample reports the upper current threshold exceeded. It returns to low line only after the lower threshold has been reported as undershot for a full debounce interval. On the high-line curve the frequency is further limited to a cap below the absolute maximum.

Top module: `blank_period_sel`

## Requirements
- R1: After reset, `high_line` is 0 and `period` equals the slow period (CLK_KHZ/FMIN_KHZ, 2083 at default parameters).
- R2: In the low-line state, a clock edge at which `sample_en` and `line_above` are both 1 sets `high_line` at that same edge.
- R3: In the high-line state, a sample with `line_below`=1 starts a debounce. `high_line` clears exactly DEBOUNCE_CYC edges after that sample edge. Further samples with `line_below`=1 do not restart the count. A sample with `line_below`=0 cancels the count, and the state stays high.
- R4: Low-line curve (`fb_code` is 10 bits, 5 mV per LSB). For fb ≥ 400 (2.0 V) the period is the fast period CLK_KHZ/FMAX_KHZ (400). For fb ≤ 320 (1.6 V) it is the slow period. In between, the period is slow − ((slow − fast)·(fb − 320)) / 80, with the division truncating.
- R5: High-line curve. The same rule as R4 applies, with 480 (2.4 V) as the upper bound and 400 (2.0 V) as the lower bound, and 80 as the divisor.
- R6: At high line, the period never goes below the cap period CLK_KHZ/FCAP_KHZ (500). Codes ≥ 480 therefore give 500.
- R7: `period` loads only at an edge where `cycle_start` is 1, using the line state held before that edge. At all other times it holds its value, whatever `fb_code` does.
- R8: `line_above` and `line_below` have no effect when `sample_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_code | input | FB_W | Feedback code, 5 mV per LSB |
| sample_en | input | 1 | Comparator outputs valid (switch on) |
| line_above | input | 1 | Line current above the upper threshold |
| line_below | input | 1 | Line current below the lower threshold |
| cycle_start | input | 1 | Load a new period for the coming cycle |
| period | output | PER_W | Registered blanking period in clock cycles |
| high_line | output | 1 | Current line state, 1 = high line |

## Verification
The bench drives the feedback codes that sit exactly on and next to each curve knee. A design that mixed up the two curves' bounds, or that used `>` where `≥` is meant, would give a period off by one interpolation step or a full curve step at those codes. On the high-line curve the bench uses codes whose interpolated period falls below the cap. A missing cap would show up there as a period under 500. For the debounce, the bench counts edges to the exact cycle of the fall, cancels one debounce midway, and repeats a below-threshold sample during another. A design that restarted the count on every sample would fall late, and one that ignored the cancel would fall when it should not.

// File: rtl/blank_period_sel.sv
module blank_period_sel #(
  parameter int CLK_KHZ      = 50000,
  parameter int FMAX_KHZ     = 125,
  parameter int FMIN_KHZ     = 24,
  parameter int FCAP_KHZ     = 100,
  parameter int FB_W         = 10,
  parameter int HL_TOP       = 480,
  parameter int HL_BOT       = 400,
  parameter int LL_TOP       = 400,
  parameter int LL_BOT       = 320,
  parameter int DEBOUNCE_CYC = 850000,
  parameter int PER_W        = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FB_W-1:0]  fb_code,
  input  logic             sample_en,
  input  logic             line_above,
  input  logic             line_below,
  input  logic             cycle_start,
  output logic [PER_W-1:0] period,
  output logic             high_line
);
  localparam int P_FAST = CLK_KHZ / FMAX_KHZ;
  localparam int P_SLOW = CLK_KHZ / FMIN_KHZ;
  localparam int P_CAP  = CLK_KHZ / FCAP_KHZ;
  localparam int SWING  = P_SLOW - P_FAST;
  localparam int DEB_W  = $clog2(DEBOUNCE_CYC + 1);

  logic             pend_q;
  logic [DEB_W-1:0] deb_q;
  int               fb_i, curve_ll, curve_hl, curve_hl_cap;

  function automatic int interp(input int fb, input int top, input int bot);
    if (fb >= top)      return P_FAST;
    else if (fb <= bot) return P_SLOW;
    else                return P_SLOW - (SWING * (fb - bot)) / (top - bot);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_line <= 1'b0;
      pend_q    <= 1'b0;
      deb_q     <= '0;
    end else if (!high_line) begin
      pend_q <= 1'b0;
      deb_q  <= '0;
      if (sample_en && line_above) high_line <= 1'b1;
    end else if (sample_en && !line_below) begin
      pend_q <= 1'b0;
      deb_q  <= '0;
    end else if (pend_q) begin
      if (deb_q == DEB_W'(DEBOUNCE_CYC - 1)) begin
        high_line <= 1'b0;
        pend_q    <= 1'b0;
        deb_q     <= '0;
      end else begin
        deb_q <= deb_q + 1'b1;
      end
    end else if (sample_en) begin
      pend_q <= 1'b1;
      deb_q  <= '0;
    end
  end

  assign fb_i         = int'(fb_code);
  assign curve_ll     = interp(fb_i, LL_TOP, LL_BOT);
  assign curve_hl     = interp(fb_i, HL_TOP, HL_BOT);
  assign curve_hl_cap = (curve_hl < P_CAP) ? P_CAP : curve_hl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           period <= PER_W'(P_SLOW);
    else if (cycle_start) period <= PER_W'(high_line ? curve_hl_cap : curve_ll);
  end
endmodule

module blank_period_sel_chk #(
  parameter int CLK_KHZ  = 50000,
  parameter int FMAX_KHZ = 125,
  parameter int FMIN_KHZ = 24,
  parameter int FCAP_KHZ = 100,
  parameter int FB_W     = 10,
  parameter int LL_BOT   = 320,
  parameter int HL_BOT   = 400,
  parameter int PER_W    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [FB_W-1:0]  fb_code,
  input logic             sample_en,
  input logic             line_above,
  input logic             line_below,
  input logic             cycle_start,
  input logic [PER_W-1:0] period,
  input logic             high_line
);
  localparam int P_FAST = CLK_KHZ / FMAX_KHZ;
  localparam int P_SLOW = CLK_KHZ / FMIN_KHZ;
  localparam int P_CAP  = CLK_KHZ / FCAP_KHZ;
  localparam int BOT_MIN = (LL_BOT < HL_BOT) ? LL_BOT : HL_BOT;

  AST_PERIOD_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(period) >= P_FAST) && (int'(period) <= P_SLOW)); // R4
  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> $stable(period)); // R7
  AST_HL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && high_line) |=> int'(period) >= P_CAP); // R6
  AST_SLOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && int'(fb_code) <= BOT_MIN) |=> int'(period) == P_SLOW); // R5
  AST_RISE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!high_line && sample_en && line_above) |=> high_line); // R2
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(high_line) |-> $past(sample_en && line_above)); // R8
  AST_CANCEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (high_line && sample_en && !line_below) |=> high_line); // R3
endmodule

bind blank_period_sel blank_period_sel_chk #(
  .CLK_KHZ(CLK_KHZ), .FMAX_KHZ(FMAX_KHZ), .FMIN_KHZ(FMIN_KHZ), .FCAP_KHZ(FCAP_KHZ),
  .FB_W(FB_W), .LL_BOT(LL_BOT), .HL_BOT(HL_BOT), .PER_W(PER_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .sample_en(sample_en),
  .line_above(line_above), .line_below(line_below), .cycle_start(cycle_start),
  .period(period), .high_line(high_line)
);

// File: tb/sim_blank_period_sel.sv
module sim_blank_period_sel;
  localparam int DEB = 40;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] fb_code = '0;
  logic sample_en = 1'b0, line_above = 1'b0, line_below = 1'b0, cycle_start = 1'b0;
  logic [11:0] period;
  logic high_line;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  blank_period_sel #(.DEBOUNCE_CYC(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .sample_en(sample_en),
    .line_above(line_above), .line_below(line_below), .cycle_start(cycle_start),
    .period(period), .high_line(high_line));

  function automatic int exp_period(input int fb, input bit hl);
    int top = hl ? 480 : 400;
    int bot = hl ? 400 : 320;
    int p;
    if (fb >= top)      p = 400;
    else if (fb <= bot) p = 2083;
    else                p = 2083 - (1683 * (fb - bot)) / 80;
    if (hl && p < 500) p = 500;
    return p;
  endfunction

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input int fb, input bit hl, input string req);
    fb_code = 10'(fb); cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
    check(int'(period), exp_period(fb, hl), req);
  endtask

  task automatic sample(input bit a, input bit b);
    sample_en = 1'b1; line_above = a; line_below = b;
    @(negedge clk);
    sample_en = 1'b0; line_above = 1'b0; line_below = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lo_pts[8] = '{0, 320, 321, 360, 399, 400, 401, 1023};
    int hi_pts[9] = '{0, 400, 401, 440, 470, 475, 479, 480, 1023};
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    check(int'(high_line), 0, "R1");
    check(int'(period), 2083, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(period), 2083, "R1");

    fb_code = 10'd500;
    repeat (5) @(negedge clk);
    check(int'(period), 2083, "R7 hold without strobe");

    foreach (lo_pts[i]) strobe(lo_pts[i], 1'b0, "R4");

    line_above = 1'b1; line_below = 1'b1;
    repeat (4) @(negedge clk);
    line_above = 1'b0; line_below = 1'b0;
    check(int'(high_line), 0, "R8 ignored without sample_en");
    strobe(450, 1'b0, "R8 curve unchanged");

    sample(1'b0, 1'b1);
    check(int'(high_line), 0, "R2 below in low state");
    sample(1'b1, 1'b0);
    check(int'(high_line), 1, "R2");

    foreach (hi_pts[i]) strobe(hi_pts[i], 1'b1, (hi_pts[i] >= 475) ? "R6" : "R5");
    for (int k = 0; k < 150; k++) strobe(int'($urandom_range(1023)), 1'b1, "R5 random");

    sample(1'b0, 1'b1);
    repeat (DEB - 1) @(negedge clk);
    check(int'(high_line), 1, "R3 before debounce end");
    @(negedge clk);
    check(int'(high_line), 0, "R3 fall cycle");

    sample(1'b1, 1'b0);
    sample(1'b0, 1'b1);
    repeat (10) @(negedge clk);
    sample(1'b0, 1'b0);
    repeat (DEB + 5) @(negedge clk);
    check(int'(high_line), 1, "R3 cancelled");

    sample(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    sample(1'b0, 1'b1);
    repeat (DEB - 6) @(negedge clk);
    check(int'(high_line), 1, "R3 no restart");
    @(negedge clk);
    check(int'(high_line), 0, "R3 no restart fall");

    for (int k = 0; k < 150; k++) strobe(int'($urandom_range(1023)), 1'b0, "R4 random");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule